// File: doc/BRIEF.md
# Status Packet Generator

The block keeps a status word of configurable width and reports it downstream as a short frame of bytes on an 8-bit bus. It uses a two-wire handshake with a downstream collector. The block raises a request line and shows the frame's address byte on the bus. The collector answers with a one-cycle start pulse when it takes that byte. The remaining bytes then follow on consecutive clocks. The status value is captured at the start pulse, so every byte of one frame describes the same status word.

Software controls the generator with a single 8-bit control write. The two low bits choose one of four reporting modes:

- off
- report once and then return to off
- report on every change of the status word
- report continuously

The six upper bits set a sequence tag that is carried in every frame. A parameter selects whether the status input passes through a register stage before the block uses it.

Top module: `stat_pkt_gen`

## Requirements
- R1: After synchronous reset the request is low, the byte bus is 0 and the mode is off.
- R2: A control write stores bits [1:0] as the mode and bits [7:2] as the sequence tag. Mode codes are 0 = off, 1 = once, 2 = on change and 3 = continuous. A write of a nonzero mode makes a report pending immediately, and a write of mode 0 cancels any pending report.
- R3: While the request is high, the bus shows the address byte. This is the parameter ADDR_BYTE, with a default of 0x38.
- R4: After the address byte, the frame continues with four bytes in this order:
  - {tag[5:0], status[1:0]}
  - status[9:2]
  - status[17:10]
  - status[25:18]
- R5: The status word is captured in the cycle in which start is seen with the request high. Later status changes do not alter the bytes of that frame.
- R6: The request drops in the cycle after an accepted start. The four frame bytes appear on the four following cycles, one per cycle.
- R7: In once mode, exactly one frame is sent and the mode then returns to off. Later status changes raise no request.
- R8: In change mode, any change of the status word makes one report pending. Changes that arrive during a transfer are merged into exactly one further frame.
- R9: In continuous mode, the request rises again in the cycle after the last frame byte.
- R10: In off mode the request stays low and start pulses have no effect.
- R11: The bus reads 0 whenever no frame is being offered or sent.
- R12: A start pulse while the request is low is ignored, and no bytes appear on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control write strobe |
| ctl_byte | input | 8 | Control value: mode in [1:0], tag in [7:2] |
| status_in | input | PAYLOAD_W | Status word to report |
| start | input | 1 | Downstream acknowledge of the address byte |
| bus_out | output | 8 | Frame byte bus |
| req | output | 1 | Frame pending request |

## Verification
The assertions assume a well-behaved collector:
- start is a one-cycle pulse;
- start is given only while the request is high, except in the cases that deliberately test that a start is ignored;
- the collector takes the following bytes on consecutive clocks with no backpressure.

The stimulus drives every input on the falling clock edge. It pulses start for exactly one cycle, and it changes the status word mid-frame only to check the capture and merging rules. The bench keeps control writes away from start pulses, so the case where both arrive in the same cycle is left unexercised.

// File: rtl/stat_pkt_gen.sv
module stat_pkt_gen #(
  parameter logic [7:0] ADDR_BYTE  = 8'h38,
  parameter int         PAYLOAD_W  = 26,
  parameter bit         REG_STATUS = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_byte,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic                 start,
  output logic [7:0]           bus_out,
  output logic                 req
);
  localparam int TAG_W      = 6;
  localparam int FRM_W      = PAYLOAD_W + TAG_W;
  localparam int DATA_BYTES = (FRM_W + 7) / 8;
  localparam int FRM_PAD_W  = 8 * DATA_BYTES;
  localparam int CNT_W      = $clog2(DATA_BYTES + 1);

  localparam logic [1:0] M_OFF  = 2'd0;
  localparam logic [1:0] M_ONCE = 2'd1;
  localparam logic [1:0] M_CHG  = 2'd2;
  localparam logic [1:0] M_CONT = 2'd3;

  logic [1:0]           mode;
  logic [TAG_W-1:0]     tag;
  logic                 pend;
  logic [CNT_W-1:0]     cnt;
  logic [PAYLOAD_W-1:0] stat, stat_prev, snap;
  logic [FRM_PAD_W-1:0] frm;
  logic [7:0]           cur_byte;
  logic                 take, changed;

  generate
    if (REG_STATUS) begin : g_reg
      logic [PAYLOAD_W-1:0] stat_r;
      always_ff @(posedge clk) begin
        if (rst) stat_r <= '0;
        else     stat_r <= status_in;
      end
      assign stat = stat_r;
    end else begin : g_pass
      assign stat = status_in;
    end
  endgenerate

  assign req     = pend && (cnt == '0);
  assign take    = start && req;
  assign changed = stat != stat_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_OFF;
      tag       <= '0;
      pend      <= 1'b0;
      stat_prev <= '0;
    end else begin
      stat_prev <= stat;
      if (ctl_we) begin
        mode <= ctl_byte[1:0];
        tag  <= ctl_byte[7:2];
      end else if (take && mode == M_ONCE) begin
        mode <= M_OFF;
      end

      if (ctl_we)                     pend <= ctl_byte[1:0] != M_OFF;
      else if (take)                  pend <= mode == M_CONT;
      else if (mode == M_CHG && changed) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      snap <= '0;
    end else if (take) begin
      cnt  <= CNT_W'(1);
      snap <= stat;
    end else if (cnt == CNT_W'(DATA_BYTES)) begin
      cnt  <= '0;
    end else if (cnt != '0) begin
      cnt  <= cnt + CNT_W'(1);
    end
  end

  assign frm = FRM_PAD_W'({snap[PAYLOAD_W-1:2], tag, snap[1:0]});

  always_comb begin
    cur_byte = 8'h00;
    for (int i = 0; i < DATA_BYTES; i++)
      if (cnt == CNT_W'(i + 1)) cur_byte = frm[8*i +: 8];
  end

  assign bus_out = (cnt != '0) ? cur_byte : (req ? ADDR_BYTE : 8'h00);
endmodule

// File: rtl/stat_pkt_gen_chk.sv
module stat_pkt_gen_chk #(
  parameter logic [7:0] ADDR_BYTE = 8'h38,
  parameter int         CNT_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_we,
  input logic             start,
  input logic             req,
  input logic [7:0]       bus_out,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt
);
  a_r3_addr_on_req: assert property (@(posedge clk) disable iff (rst)
    req |-> bus_out == ADDR_BYTE);

  a_r6_req_drops: assert property (@(posedge clk) disable iff (rst)
    (start && req) |=> !req);

  a_r6_first_byte: assert property (@(posedge clk) disable iff (rst)
    (start && req) |=> cnt == CNT_W'(1));

  a_r7_once_returns: assert property (@(posedge clk) disable iff (rst)
    (start && req && mode == 2'd1 && !ctl_we) |=> mode == 2'd0);

  a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> !req);

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (start && !req && cnt == '0) |=> cnt == '0);
endmodule

bind stat_pkt_gen stat_pkt_gen_chk #(.ADDR_BYTE(ADDR_BYTE), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .start(start), .req(req),
  .bus_out(bus_out), .mode(mode), .cnt(cnt)
);

// File: tb/stat_pkt_gen_tb.sv
module stat_pkt_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_byte = '0;
  logic [25:0] status_in = '0;
  logic        start = 1'b0;
  logic [7:0]  bus_out;
  logic        req;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stat_pkt_gen u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
    .status_in(status_in), .start(start), .bus_out(bus_out), .req(req)
  );

  // {control byte, status word (26 bits used)}
  localparam logic [39:0] VEC [4] = '{
    {8'h05, 32'h03ABCDEF},
    {8'hFD, 32'h00000002},
    {8'h81, 32'h02AAAAAA},
    {8'h01, 32'h01555555}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    ctl_byte = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input logic [5:0] tg, input logic [25:0] s, input int k);
    case (k)
      0: return {tg, s[1:0]};
      1: return s[9:2];
      2: return s[17:10];
      default: return s[25:18];
    endcase
  endfunction

  task automatic recv(input logic [5:0] tg, input logic [25:0] s, input logic [7:0] after,
                      input bit mid, input logic [25:0] m1, input logic [25:0] m2);
    chk(req === 1'b1, "R3 req", int'(req), 1);
    chk(bus_out === 8'h38, "R3 addr", int'(bus_out), 8'h38);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req === 1'b0, "R6 req drop", int'(req), 0);
    chk(bus_out === exp_byte(tg, s, 0), "R4 byte1", int'(bus_out), int'(exp_byte(tg, s, 0)));
    if (mid) status_in = m1;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      if (mid && k == 1) status_in = m2;
      chk(bus_out === exp_byte(tg, s, k), "R4 R5 byte", int'(bus_out), int'(exp_byte(tg, s, k)));
    end
    @(negedge clk);
    chk(bus_out === after, "R9 R11 after frame", int'(bus_out), int'(after));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req === 1'b0, "R1 req", int'(req), 0);
    chk(bus_out === 8'h00, "R1 bus", int'(bus_out), 0);

    // R2 R4 R7: table of once-mode reports
    foreach (VEC[i]) begin
      status_in = VEC[i][25:0];
      @(negedge clk);
      ctl_write(VEC[i][39:32]);
      recv(VEC[i][39:34], VEC[i][25:0], 8'h00, 0, '0, '0);
      status_in = ~VEC[i][25:0];
      repeat (3) @(negedge clk);
      chk(req === 1'b0, "R7 once stays off", int'(req), 0);
    end

    // R10: off mode ignores start
    ctl_write(8'h00);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(bus_out === 8'h00, "R10 off start", int'(bus_out), 0);
    chk(req === 1'b0, "R10 off req", int'(req), 0);

    // R2 cancel: once then off
    ctl_write(8'h09);
    chk(req === 1'b1, "R2 pending", int'(req), 1);
    ctl_write(8'h08);
    chk(req === 1'b0, "R2 cancel", int'(req), 0);

    // R8: change mode
    status_in = 26'h0123456;
    @(negedge clk);
    ctl_write(8'h2A);
    recv(6'h0A, 26'h0123456, 8'h00, 0, '0, '0);
    // R12: start with no request ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(bus_out === 8'h00, "R12 ignored", int'(bus_out), 0);
    status_in = 26'h0BEEF00;
    @(negedge clk);
    chk(req === 1'b0, "R8 change latency", int'(req), 0);
    @(negedge clk);
    chk(req === 1'b1, "R8 change raises req", int'(req), 1);
    recv(6'h0A, 26'h0BEEF00, 8'h38, 1, 26'h1111111, 26'h2222222);
    recv(6'h0A, 26'h2222222, 8'h00, 0, '0, '0);
    repeat (4) @(negedge clk);
    chk(req === 1'b0, "R8 single extra frame", int'(req), 0);

    // R9: continuous
    ctl_write(8'hC3);
    recv(6'h30, 26'h2222222, 8'h38, 0, '0, '0);
    recv(6'h30, 26'h2222222, 8'h38, 0, '0, '0);
    ctl_write(8'h00);
    chk(req === 1'b0, "R10 off after cont", int'(req), 0);

    // R1: reset mid-offer
    ctl_write(8'h03);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(req === 1'b0, "R1 reset req", int'(req), 0);
    chk(bus_out === 8'h00, "R1 reset bus", int'(bus_out), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule